// File: doc/BRIEF.md
# Power Mode and Clock Controller

This block tracks the operating mode of a small microcontroller and derives the clock enable that its bus masters run on. Software picks a divide ratio through a small configuration register. The block applies that ratio only at the end of the current bus cycle, so a bus access never straddles two clock rates. The bus masters (CPU and DMA engines) then advance only on cycles where `bm_clk_en` is high. Peripherals stay on the undivided clock and never see this enable.

A sleep request from the CPU enters one of two low-power states, chosen by the standby-select bit. Light sleep halts only the CPU. Software standby also stops the bus-master enable. Each state wakes on its own set of events, and on wake-up the block returns to the divided or undivided mode that was active before. Reset and watchdog overflow restart the block at full rate. A low hardware-standby pin overrides every other event except reset.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: While `rst_n` is low, `mode` is 0 (reset), `cfg_rdata` is 0, `cpu_halt` is 1 and `bm_clk_en` is 0. On the first clock edge after `rst_n` rises, `mode` becomes 1 (high-speed).
- R2: `cfg_we` in mode 1 or 2 stores `cfg_wdata`, with bit 3 as the standby-select and bits 2:0 as the clock-select. A clock-select of 6 or 7 is stored as 5. `cfg_rdata` returns `{standby-select, clock-select}`. Writes in any other mode leave the register unchanged.
- R3: In modes 1 and 2 the mode changes between high-speed (1) and medium-speed (2) only at an edge where `bus_end` is high. The new mode is 2 if the stored clock-select before that edge is nonzero, and 1 otherwise.
- R4: In mode 2 with an applied select k, `bm_clk_en` is a one-cycle pulse every 2^k cycles. In mode 1, once the ratio has settled, `bm_clk_en` is high on every cycle.
- R5: A new ratio takes over only after the pulse that ends the current period, so every gap between two pulses equals the old or the new period.
- R6: `sleep_req` in mode 1 or 2 with standby-select 0 enters mode 3 (sleep). In sleep, `cpu_halt` is 1 and `bm_clk_en` keeps pulsing at the applied ratio.
- R7: Sleep is left on `nmi`, or on `irq_any` while `irq_dis` is 0. `irq_any` with `irq_dis` at 1 does not wake. The mode then returns to the one active before sleep.
- R8: `sleep_req` with standby-select 1 enters mode 4 (software standby), where `bm_clk_en` is 0 and `cpu_halt` is 1. Only `ext_irq` or `nmi` wakes it. On wake, the previous mode and ratio are restored.
- R9: `wdt_ovf` gives mode 0 on the next edge with `cfg_rdata` cleared to 0, and mode 1 on the edge after that.
- R10: `hstby_n` low gives mode 5 (hardware standby) on the next edge from any mode, unless `wdt_ovf` is high. It clears the register. Mode 5 is kept after `hstby_n` rises, until a reset or watchdog overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous reset pin, active low |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| hstby_n | input | 1 | Hardware standby pin, active low |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 4 | Write data: bit 3 standby-select, bits 2:0 clock-select |
| cfg_rdata | output | 4 | Configuration register readback |
| sleep_req | input | 1 | Sleep instruction executed |
| bus_end | input | 1 | Current bus cycle ends this clock |
| nmi | input | 1 | Non-maskable interrupt |
| irq_any | input | 1 | Some maskable interrupt is pending |
| irq_dis | input | 1 | Maskable interrupts are disabled or masked |
| ext_irq | input | 1 | External interrupt pin event |
| mode | output | 3 | Current mode code (0 to 5) |
| bm_clk_en | output | 1 | Bus-master clock enable |
| cpu_halt | output | 1 | CPU halted |

## Verification
The bench holds `bus_end` low for several cycles after each select write. A design that switches rate at the write instead of at the bus-cycle end fails the mode check there. Every pulse gap is measured while the ratio is moved between /4, /32 and /2. A divider that reloads mid-period would produce a gap that matches neither period.

A masked interrupt is raised in sleep and an internal interrupt in software standby. A wake condition that ignores the mask, or lets internal interrupts end standby, leaves the mode too early. Hardware standby is entered from sleep and then left with the pin high. A design that resumes without reset, or keeps the old select, shows a wrong mode or readback.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
    parameter int SEL_W = 3;
    parameter int CNT_W = 5;

    typedef enum logic [2:0] {
        M_RESET  = 3'd0,
        M_HIGH   = 3'd1,
        M_MED    = 3'd2,
        M_SLEEP  = 3'd3,
        M_SSTBY  = 3'd4,
        M_HWSTBY = 3'd5
    } mode_e;

    function automatic logic is_run(input mode_e m);
        return (m == M_HIGH) || (m == M_MED);
    endfunction
endpackage

// File: rtl/pcc_regs.sv
module pcc_regs #(
    parameter int SEL_W = 3,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_ok,
    input  logic             we,
    input  logic [SEL_W:0]   wdata,
    output logic [SEL_W-1:0] sel_o,
    output logic             stby_o
);
    localparam logic [SEL_W-1:0] MAX_SEL = SEL_W'(CNT_W);

    typedef struct packed {
        logic             stby;
        logic [SEL_W-1:0] sel;
    } reg_t;

    reg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else if (we && wr_ok) begin
            st_d.stby = wdata[SEL_W];
            st_d.sel  = (wdata[SEL_W-1:0] > MAX_SEL) ? MAX_SEL : wdata[SEL_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sel_o  = st_q.sel;
    assign stby_o = st_q.stby;
endmodule

// File: rtl/pcc_mode_fsm.sv
module pcc_mode_fsm
    import pcc_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wdt_ovf,
    input  logic             hstby_n,
    input  logic             sleep_req,
    input  logic             bus_end,
    input  logic             nmi,
    input  logic             irq_any,
    input  logic             irq_dis,
    input  logic             ext_irq,
    input  logic             stby_sel,
    input  logic [SEL_W-1:0] sel_cfg,
    output mode_e            mode_o,
    output logic [SEL_W-1:0] act_sel_o
);
    typedef struct packed {
        mode_e            mode;
        logic [SEL_W-1:0] act_sel;
    } fsm_t;

    fsm_t st_d, st_q;

    function automatic mode_e run_of(input logic [SEL_W-1:0] s);
        return (s != '0) ? M_MED : M_HIGH;
    endfunction

    always_comb begin
        st_d = st_q;
        if (wdt_ovf) begin
            st_d.mode    = M_RESET;
            st_d.act_sel = '0;
        end else if (!hstby_n) begin
            st_d.mode    = M_HWSTBY;
            st_d.act_sel = '0;
        end else begin
            unique case (st_q.mode)
                M_RESET: st_d.mode = M_HIGH;
                M_HIGH, M_MED: begin
                    // the ratio in use only moves at a bus-cycle boundary
                    if (bus_end) st_d.act_sel = sel_cfg;
                    if (sleep_req) st_d.mode = stby_sel ? M_SSTBY : M_SLEEP;
                    else           st_d.mode = run_of(st_d.act_sel);
                end
                M_SLEEP: begin
                    if (nmi || (irq_any && !irq_dis)) st_d.mode = run_of(st_q.act_sel);
                end
                M_SSTBY: begin
                    if (nmi || ext_irq) st_d.mode = run_of(st_q.act_sel);
                end
                M_HWSTBY: st_d.mode = M_HWSTBY;
                default:  st_d.mode = M_RESET;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode    <= M_RESET;
            st_q.act_sel <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o    = st_q.mode;
    assign act_sel_o = st_q.act_sel;
endmodule

// File: rtl/pcc_clkdiv.sv
module pcc_clkdiv #(
    parameter int SEL_W = 3,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [SEL_W-1:0] sel_req,
    output logic             en
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_t;

    div_t st_d, st_q;
    logic [CNT_W:0] span;

    always_comb begin
        st_d = st_q;
        span = (CNT_W+1)'(1) << sel_req;
        if (!active) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == '0) begin
            // reload only at a period boundary, picking up the latest ratio
            st_d.cnt = CNT_W'(span - 1'b1);
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en = active && (st_q.cnt == '0);
endmodule

// File: rtl/pwr_clk_ctrl.sv
module pwr_clk_ctrl
    import pcc_pkg::*;
#(
    parameter int SEL_W = pcc_pkg::SEL_W,
    parameter int CNT_W = pcc_pkg::CNT_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wdt_ovf,
    input  logic           hstby_n,
    input  logic           cfg_we,
    input  logic [SEL_W:0] cfg_wdata,
    output logic [SEL_W:0] cfg_rdata,
    input  logic           sleep_req,
    input  logic           bus_end,
    input  logic           nmi,
    input  logic           irq_any,
    input  logic           irq_dis,
    input  logic           ext_irq,
    output logic [2:0]     mode,
    output logic           bm_clk_en,
    output logic           cpu_halt
);
    mode_e            mode_w;
    logic [SEL_W-1:0] sel_cfg;
    logic             stby_sel;
    logic [SEL_W-1:0] act_sel;
    logic             div_active;

    pcc_regs #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (wdt_ovf || !hstby_n),
        .wr_ok  (is_run(mode_w)),
        .we     (cfg_we),
        .wdata  (cfg_wdata),
        .sel_o  (sel_cfg),
        .stby_o (stby_sel)
    );

    pcc_mode_fsm #(.SEL_W(SEL_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wdt_ovf   (wdt_ovf),
        .hstby_n   (hstby_n),
        .sleep_req (sleep_req),
        .bus_end   (bus_end),
        .nmi       (nmi),
        .irq_any   (irq_any),
        .irq_dis   (irq_dis),
        .ext_irq   (ext_irq),
        .stby_sel  (stby_sel),
        .sel_cfg   (sel_cfg),
        .mode_o    (mode_w),
        .act_sel_o (act_sel)
    );

    assign div_active = is_run(mode_w) || (mode_w == M_SLEEP);

    pcc_clkdiv #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (div_active),
        .sel_req (act_sel),
        .en      (bm_clk_en)
    );

    assign cfg_rdata = {stby_sel, sel_cfg};
    assign mode      = mode_w;
    assign cpu_halt  = !is_run(mode_w);
endmodule

// File: rtl/pcc_checker.sv
module pcc_checker #(
    parameter int SEL_W = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           wdt_ovf,
    input logic           hstby_n,
    input logic           bus_end,
    input logic [SEL_W:0] cfg_rdata,
    input logic [2:0]     mode,
    input logic           bm_clk_en,
    input logic           cpu_halt
);
    logic run_now;
    assign run_now = (mode == 3'd1) || (mode == 3'd2);

    // R3: high/medium swaps only happen at a bus-cycle end
    a_r3_swap_at_bus_end: assert property (@(posedge clk) disable iff (!rst_n)
        (run_now && $past(run_now) && mode != $past(mode)) |-> $past(bus_end));

    // R9: watchdog overflow forces reset and a clear register
    a_r9_wdt_reset: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_ovf |=> (mode == 3'd0) && (cfg_rdata == '0));

    // R10: hardware standby pin wins over all but reset
    a_r10_hw_standby: assert property (@(posedge clk) disable iff (!rst_n)
        (!hstby_n && !wdt_ovf) |=> (mode == 3'd5));

    // R8: no bus-master enable in software standby
    a_r8_sstby_no_clk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd4) |-> !bm_clk_en);

    // R6: CPU halted in sleep
    a_r6_sleep_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd3) |-> cpu_halt);
endmodule

bind pwr_clk_ctrl pcc_checker #(.SEL_W(SEL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wdt_ovf   (wdt_ovf),
    .hstby_n   (hstby_n),
    .bus_end   (bus_end),
    .cfg_rdata (cfg_rdata),
    .mode      (mode),
    .bm_clk_en (bm_clk_en),
    .cpu_halt  (cpu_halt)
);

// File: tb/pwr_clk_ctrl_bench.sv
module pwr_clk_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wdt_ovf = 1'b0;
    logic       hstby_n = 1'b1;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_wdata = '0;
    logic [3:0] cfg_rdata;
    logic       sleep_req = 1'b0;
    logic       bus_end = 1'b0;
    logic       nmi = 1'b0;
    logic       irq_any = 1'b0;
    logic       irq_dis = 1'b0;
    logic       ext_irq = 1'b0;
    logic [2:0] mode;
    logic       bm_clk_en;
    logic       cpu_halt;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    pwr_clk_ctrl u_pwr_clk_ctrl (
        .clk(clk), .rst_n(rst_n), .wdt_ovf(wdt_ovf), .hstby_n(hstby_n),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .sleep_req(sleep_req), .bus_end(bus_end), .nmi(nmi),
        .irq_any(irq_any), .irq_dis(irq_dis), .ext_irq(ext_irq),
        .mode(mode), .bm_clk_en(bm_clk_en), .cpu_halt(cpu_halt)
    );

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic stby, input logic [2:0] sel);
        cfg_we = 1'b1;
        cfg_wdata = {stby, sel};
        step(1);
        cfg_we = 1'b0;
    endtask

    task automatic end_bus;
        bus_end = 1'b1;
        step(1);
        bus_end = 1'b0;
    endtask

    task automatic pulse_sleep;
        sleep_req = 1'b1;
        step(1);
        sleep_req = 1'b0;
    endtask

    // cycles from one enable pulse to the next
    task automatic gap(output int g);
        int guard = 0;
        while (!bm_clk_en && guard < 100) begin step(1); guard++; end
        g = 0;
        do begin step(1); g++; end while (!bm_clk_en && g < 100);
    endtask

    task automatic check_period(input string tag, input int exp);
        int g;
        for (int k = 0; k < 3; k++) begin
            gap(g);
            chk(tag, g, exp);
        end
    endtask

    // every gap in a window must be one of two periods
    task automatic check_gaps(input string tag, input int a, input int b, input int n);
        int g;
        for (int k = 0; k < n; k++) begin
            gap(g);
            chk(tag, ((g == a) || (g == b)) ? g : -g, (g == b) ? b : a);
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        step(2);
        chk("R1 mode in reset", mode, 0);
        chk("R1 rdata in reset", cfg_rdata, 0);
        chk("R1 halt in reset", cpu_halt, 1);
        chk("R1 enable in reset", bm_clk_en, 0);
        rst_n = 1'b1;
        step(1);
        chk("R1 high-speed after reset", mode, 1);
        chk("R1 halt released", cpu_halt, 0);
    endtask

    task automatic t_switch;
        wr(1'b0, 3'd2);
        chk("R2 readback", cfg_rdata, 2);
        step(5);
        chk("R3 no switch without bus end", mode, 1);
        end_bus;
        chk("R3 medium at bus end", mode, 2);
        check_period("R4 divide by 4", 4);
    endtask

    task automatic t_ratio;
        wr(1'b0, 3'd5);
        end_bus;
        check_gaps("R5 gaps 4 to 32", 4, 32, 4);
        check_period("R4 divide by 32", 32);
        wr(1'b0, 3'd1);
        end_bus;
        check_gaps("R5 gaps 32 to 2", 32, 2, 4);
        check_period("R4 divide by 2", 2);
    endtask

    task automatic t_back_high;
        int hi;
        wr(1'b0, 3'd0);
        step(3);
        chk("R3 stays medium until bus end", mode, 2);
        end_bus;
        chk("R3 high at bus end", mode, 1);
        step(40);
        hi = 0;
        for (int k = 0; k < 5; k++) begin hi += bm_clk_en; step(1); end
        chk("R4 full rate in high", hi, 5);
    endtask

    task automatic t_reserved;
        wr(1'b0, 3'd6);
        chk("R2 select 6 stored as 5", cfg_rdata, 5);
        wr(1'b0, 3'd7);
        chk("R2 select 7 stored as 5", cfg_rdata, 5);
        wr(1'b0, 3'd3);
        end_bus;
        chk("R3 medium for /8", mode, 2);
    endtask

    task automatic t_sleep;
        pulse_sleep;
        chk("R6 sleep entered", mode, 3);
        chk("R6 halt in sleep", cpu_halt, 1);
        check_period("R6 enable keeps /8 in sleep", 8);
        irq_any = 1'b1; irq_dis = 1'b1;
        step(3);
        chk("R7 masked irq does not wake", mode, 3);
        wr(1'b0, 3'd1);
        chk("R2 write ignored in sleep", cfg_rdata, 3);
        irq_dis = 1'b0;
        step(1);
        chk("R7 unmasked irq wakes to medium", mode, 2);
        irq_any = 1'b0;
        pulse_sleep;
        chk("R6 sleep again", mode, 3);
        nmi = 1'b1;
        step(1);
        nmi = 1'b0;
        chk("R7 nmi wakes", mode, 2);
    endtask

    task automatic t_sstby;
        int seen;
        wr(1'b1, 3'd3);
        chk("R2 standby bit readback", cfg_rdata, 11);
        pulse_sleep;
        chk("R8 software standby", mode, 4);
        seen = 0;
        for (int k = 0; k < 40; k++) begin seen += bm_clk_en; step(1); end
        chk("R8 no enable in standby", seen, 0);
        chk("R8 halt in standby", cpu_halt, 1);
        irq_any = 1'b1;
        step(5);
        irq_any = 1'b0;
        chk("R8 internal irq ignored", mode, 4);
        ext_irq = 1'b1;
        step(1);
        ext_irq = 1'b0;
        chk("R8 external irq restores medium", mode, 2);
        check_period("R8 ratio restored", 8);
        wr(1'b0, 3'd3);
    endtask

    task automatic t_wdt;
        wdt_ovf = 1'b1;
        step(1);
        wdt_ovf = 1'b0;
        chk("R9 reset on overflow", mode, 0);
        chk("R9 register cleared", cfg_rdata, 0);
        step(1);
        chk("R9 high-speed after overflow", mode, 1);
    endtask

    task automatic t_hwstby;
        wr(1'b0, 3'd2);
        end_bus;
        pulse_sleep;
        chk("R6 sleep before hw standby", mode, 3);
        hstby_n = 1'b0;
        step(1);
        chk("R10 hw standby from sleep", mode, 5);
        chk("R10 register cleared", cfg_rdata, 0);
        chk("R10 enable off", bm_clk_en, 0);
        hstby_n = 1'b1;
        step(5);
        chk("R10 held after pin rises", mode, 5);
        ext_irq = 1'b1; nmi = 1'b1;
        step(2);
        ext_irq = 1'b0; nmi = 1'b0;
        wr(1'b0, 3'd4);
        chk("R10 wake events ignored", mode, 5);
        chk("R10 write ignored", cfg_rdata, 0);
        wdt_ovf = 1'b1;
        step(1);
        wdt_ovf = 1'b0;
        chk("R9 overflow leaves hw standby", mode, 0);
        step(1);
        chk("R9 then high-speed", mode, 1);
        hstby_n = 1'b0; sleep_req = 1'b1;
        step(1);
        hstby_n = 1'b1; sleep_req = 1'b0;
        chk("R10 pin beats sleep request", mode, 5);
        rst_n = 1'b0;
        step(1);
        chk("R1 reset from hw standby", mode, 0);
        rst_n = 1'b1;
        step(1);
        chk("R1 high-speed after reset", mode, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #1;
        t_reset;
        t_switch;
        t_ratio;
        t_back_high;
        t_reserved;
        t_sleep;
        t_sstby;
        t_wdt;
        t_hwstby;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule